// File: doc/BRIEF.md
# UART Automatic Power-Down Controller

This block decides, cycle by cycle, whether the transmit half and the receive half of one serial port channel may sleep. Each half is watched on its own. The transmit half sleeps when its holding buffer and its shift register are both empty. The receive half sleeps when its FIFO is empty and its bit engine is hunting for a start bit. The block drives a powerdown flag and a clock-enable for each half to the surrounding datapath.

A half wakes on its own event. For the transmitter, that event is a host write into the holding buffer. The clock enable rises in the same cycle as the write strobe, so the written byte is captured. For the receiver, the event is any edge on the serial input line. A direct powerdown input overrides both halves. A separate ring-indicator change flag stays live whatever the power state.

The serial input line and the ring-indicator line are asynchronous. Both pass through a synchronizer with parameterized depth before edge detection. The automatic mode is enabled per half by two configuration bits.

Top module: `uart_autopd_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_pd`, `rx_pd` and `ri_irq` are 0 and both clock enables are 1.
- R2: With `auto_en_tx` at 1, `tx_pd` rises at the clock edge that ends the second consecutive cycle in which `thr_empty` and `tsr_empty` are both 1 and no write is seen.
- R3: With `auto_en_rx` at 1, `rx_pd` rises at the clock edge that ends the second consecutive cycle in which `rx_fifo_empty` and `rx_hunt` are both 1 and no line edge is seen. One condition alone never causes entry.
- R4: When a half's auto-enable bit is 0 and `force_pd` is 0, that half's powerdown flag is 0 after the next edge, including when the half was already asleep.
- R5: A cycle with `thr_wr` at 1 and `force_pd` at 0 raises `tx_clk_en` in that same cycle and clears `tx_pd` at the next edge. This holds even when the idle condition is also present.
- R6: A level change on `rxd_in`, in either direction, that is sampled at clock edge k clears `rx_pd` at edge k+2 (with two synchronizer stages). During the cycle before that edge, `rx_clk_en` is 1.
- R7: After a wake cycle, a half can sleep again only after the idle condition has held through one further full cycle. The earliest re-entry is therefore two edges after the wake edge.
- R8: `force_pd` at 1 sets both powerdown flags at the next edge and holds both clock enables at 0, whatever the wake events. After `force_pd` is released, each half follows the automatic rules again.
- R9: `ri_irq` sets two edges after a sampled change of `ri_in`, in any power state. It clears one edge after `ri_clr`. A new change wins over a clear in the same cycle.
- R10: A sleeping half whose idle condition drops, with `force_pd` at 0, wakes at the next edge even if no wake event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en_tx | input | 1 | Configuration bit 4: automatic sleep of the transmit half |
| auto_en_rx | input | 1 | Configuration bit 5: automatic sleep of the receive half |
| force_pd | input | 1 | Direct powerdown of both halves |
| thr_wr | input | 1 | Host write strobe into the transmit holding buffer |
| thr_empty | input | 1 | Transmit holding buffer empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| rx_hunt | input | 1 | Receiver idle and searching for a start bit |
| rxd_in | input | 1 | Asynchronous serial input line |
| ri_in | input | 1 | Asynchronous ring-indicator line |
| ri_clr | input | 1 | Clears the ring-indicator change flag |
| tx_pd | output | 1 | Transmit half is powered down |
| rx_pd | output | 1 | Receive half is powered down |
| tx_clk_en | output | 1 | Clock enable of the transmit half |
| rx_clk_en | output | 1 | Clock enable of the receive half |
| ri_irq | output | 1 | Sticky ring-indicator change flag |

## Verification
The assertions assume that every input except `rxd_in` and `ri_in` is synchronous to `clk`. They also assume that the status inputs reflect the datapath of the current cycle, so an idle condition and a write strobe in the same cycle are a legal combination that the wake rule must resolve. The bench respects this by changing every input only on the falling clock edge. It toggles the two asynchronous lines at that same point, so a change is sampled at a known rising edge. A long phase with random stimulus also keeps to falling-edge updates. It deliberately produces simultaneous write, idle, force and clear combinations.

// File: rtl/uart_pd_pkg.sv
package uart_pd_pkg;

  typedef enum logic {
    PWR_ON   = 1'b0,
    PWR_DOWN = 1'b1
  } pwr_state_e;

  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned NUM_ASYNC_LINES = 2;
  localparam int unsigned LINE_RXD = 0;
  localparam int unsigned LINE_RI  = 1;

endpackage

// File: rtl/pd_line_sync.sv
module pd_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic toggle
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q[0] <= RST_VAL;
    else     sh_q[0] <= line_in;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sh_q[i] <= RST_VAL;
      else     sh_q[i] <= sh_q[i-1];
    end
  end

  assign toggle = sh_q[LAST] ^ sh_q[LAST-1];

endmodule

// File: rtl/pd_half_ctrl.sv
module pd_half_ctrl
  import uart_pd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic idle,
  input  logic wake,
  input  logic force_pd,
  output logic pd,
  output logic clk_en
);
  pwr_state_e st_q, st_d;
  logic       seen_q;

  always_comb begin
    st_d = st_q;
    if (force_pd)                        st_d = PWR_DOWN;
    else if (wake || !auto_en || !idle)  st_d = PWR_ON;
    else if (st_q == PWR_ON && seen_q)   st_d = PWR_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PWR_ON;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= idle && !wake;
    end
  end

  assign pd     = (st_q == PWR_DOWN);
  assign clk_en = !pd || (wake && !force_pd);

endmodule

// File: rtl/uart_autopd_ctrl.sv
module uart_autopd_ctrl
  import uart_pd_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_en_tx,
  input  logic auto_en_rx,
  input  logic force_pd,
  input  logic thr_wr,
  input  logic thr_empty,
  input  logic tsr_empty,
  input  logic rx_fifo_empty,
  input  logic rx_hunt,
  input  logic rxd_in,
  input  logic ri_in,
  input  logic ri_clr,
  output logic tx_pd,
  output logic rx_pd,
  output logic tx_clk_en,
  output logic rx_clk_en,
  output logic ri_irq
);
  logic [NUM_ASYNC_LINES-1:0] line_raw;
  logic [NUM_ASYNC_LINES-1:0] line_tgl;
  logic                       ri_irq_q;

  assign line_raw[LINE_RXD] = rxd_in;
  assign line_raw[LINE_RI]  = ri_in;

  for (genvar g = 0; g < NUM_ASYNC_LINES; g++) begin : g_sync
    pd_line_sync #(
      .STAGES  (SYNC_DEPTH),
      .RST_VAL (1'b1)
    ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .line_in (line_raw[g]),
      .toggle  (line_tgl[g])
    );
  end

  pd_half_ctrl u_tx_half (
    .clk      (clk),
    .rst      (rst),
    .auto_en  (auto_en_tx),
    .idle     (thr_empty && tsr_empty),
    .wake     (thr_wr),
    .force_pd (force_pd),
    .pd       (tx_pd),
    .clk_en   (tx_clk_en)
  );

  pd_half_ctrl u_rx_half (
    .clk      (clk),
    .rst      (rst),
    .auto_en  (auto_en_rx),
    .idle     (rx_fifo_empty && rx_hunt),
    .wake     (line_tgl[LINE_RXD]),
    .force_pd (force_pd),
    .pd       (rx_pd),
    .clk_en   (rx_clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst)                    ri_irq_q <= 1'b0;
    else if (line_tgl[LINE_RI]) ri_irq_q <= 1'b1;
    else if (ri_clr)            ri_irq_q <= 1'b0;
  end

  assign ri_irq = ri_irq_q;

endmodule

// File: rtl/uart_autopd_chk.sv
module uart_autopd_chk (
  input logic clk,
  input logic rst,
  input logic auto_en_tx,
  input logic auto_en_rx,
  input logic force_pd,
  input logic thr_wr,
  input logic thr_empty,
  input logic tsr_empty,
  input logic rx_fifo_empty,
  input logic rx_hunt,
  input logic ri_clr,
  input logic tx_pd,
  input logic rx_pd,
  input logic tx_clk_en,
  input logic rx_clk_en,
  input logic ri_irq
);

  AST_FORCE_BOTH_DOWN: assert property (@(posedge clk) disable iff (rst)
    force_pd |=> (tx_pd && rx_pd)); // R8

  AST_FORCE_GATES_CLK: assert property (@(posedge clk) disable iff (rst)
    (force_pd && tx_pd && rx_pd) |-> (!tx_clk_en && !rx_clk_en)); // R8

  AST_TX_WRITE_WAKES: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !force_pd) |=> !tx_pd); // R5

  AST_TX_WRITE_CLK_SAME: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !force_pd) |-> tx_clk_en); // R5

  AST_TX_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_pd) |-> ($past(force_pd) || $past(auto_en_tx && thr_empty && tsr_empty))); // R2

  AST_RX_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_pd) |-> ($past(force_pd) || $past(auto_en_rx && rx_fifo_empty && rx_hunt))); // R3

  AST_TX_AUTO_OFF: assert property (@(posedge clk) disable iff (rst)
    (!force_pd && !auto_en_tx) |=> !tx_pd); // R4

  AST_RX_AUTO_OFF: assert property (@(posedge clk) disable iff (rst)
    (!force_pd && !auto_en_rx) |=> !rx_pd); // R4

  AST_TX_BUSY_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!force_pd && !(thr_empty && tsr_empty)) |=> !tx_pd); // R10

  AST_RX_BUSY_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!force_pd && !(rx_fifo_empty && rx_hunt)) |=> !rx_pd); // R10

  AST_RI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ri_irq && !ri_clr) |=> ri_irq); // R9

endmodule

bind uart_autopd_ctrl uart_autopd_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .auto_en_tx    (auto_en_tx),
  .auto_en_rx    (auto_en_rx),
  .force_pd      (force_pd),
  .thr_wr        (thr_wr),
  .thr_empty     (thr_empty),
  .tsr_empty     (tsr_empty),
  .rx_fifo_empty (rx_fifo_empty),
  .rx_hunt       (rx_hunt),
  .ri_clr        (ri_clr),
  .tx_pd         (tx_pd),
  .rx_pd         (rx_pd),
  .tx_clk_en     (tx_clk_en),
  .rx_clk_en     (rx_clk_en),
  .ri_irq        (ri_irq)
);

// File: tb/uart_autopd_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_autopd_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_en_tx = 1'b0, auto_en_rx = 1'b0, force_pd = 1'b0;
  logic thr_wr = 1'b0, thr_empty = 1'b0, tsr_empty = 1'b0;
  logic rx_fifo_empty = 1'b0, rx_hunt = 1'b0;
  logic rxd_in = 1'b1, ri_in = 1'b1, ri_clr = 1'b0;
  logic tx_pd, rx_pd, tx_clk_en, rx_clk_en, ri_irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  string req   = "R1";
  bit    live  = 1'b0;
  bit    done  = 1'b0;

  // reference model state
  bit m_txpd = 0, m_rxpd = 0, m_txs = 0, m_rxs = 0, m_ri = 0;
  bit rq[$];
  bit iq[$];

  always #4 clk = ~clk;

  uart_autopd_ctrl dut_i (
    .clk(clk), .rst(rst), .auto_en_tx(auto_en_tx), .auto_en_rx(auto_en_rx),
    .force_pd(force_pd), .thr_wr(thr_wr), .thr_empty(thr_empty),
    .tsr_empty(tsr_empty), .rx_fifo_empty(rx_fifo_empty), .rx_hunt(rx_hunt),
    .rxd_in(rxd_in), .ri_in(ri_in), .ri_clr(ri_clr), .tx_pd(tx_pd),
    .rx_pd(rx_pd), .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en), .ri_irq(ri_irq)
  );

  task automatic cmp1(input string nm, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  function automatic bit line_moved(input bit q[$]);
    return q[1] != q[2];
  endfunction

  task automatic tick();
    bit tx_idle, rx_idle, rxe, rie;
    #1;
    rxe = line_moved(rq);
    rie = line_moved(iq);
    if (live) begin
      cmp1("tx_pd", tx_pd, m_txpd);
      cmp1("rx_pd", rx_pd, m_rxpd);
      cmp1("tx_clk_en", tx_clk_en, !m_txpd || (thr_wr && !force_pd));
      cmp1("rx_clk_en", rx_clk_en, !m_rxpd || (rxe && !force_pd));
      cmp1("ri_irq", ri_irq, m_ri);
    end
    @(posedge clk);
    if (rst) begin
      m_txpd = 0; m_rxpd = 0; m_txs = 0; m_rxs = 0; m_ri = 0;
      rq = '{1'b1, 1'b1, 1'b1};
      iq = '{1'b1, 1'b1, 1'b1};
    end else begin
      tx_idle = thr_empty && tsr_empty;
      rx_idle = rx_fifo_empty && rx_hunt;
      if (force_pd) m_txpd = 1;
      else if (thr_wr || !auto_en_tx || !tx_idle) m_txpd = 0;
      else if (!m_txpd) m_txpd = m_txs;
      m_txs = tx_idle && !thr_wr;
      if (force_pd) m_rxpd = 1;
      else if (rxe || !auto_en_rx || !rx_idle) m_rxpd = 0;
      else if (!m_rxpd) m_rxpd = m_rxs;
      m_rxs = rx_idle && !rxe;
      if (rie) m_ri = 1;
      else if (ri_clr) m_ri = 0;
      rq.push_front(rxd_in); void'(rq.pop_back());
      iq.push_front(ri_in);  void'(iq.pop_back());
    end
    live = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
  end

  initial begin
    rq = '{1'b1, 1'b1, 1'b1};
    iq = '{1'b1, 1'b1, 1'b1};
    // R1: reset state
    req = "R1"; run(3);
    rst = 1'b0; run(2);

    // R2: transmit entry after two idle cycles
    req = "R2"; auto_en_tx = 1; thr_empty = 1; run(1);
    tsr_empty = 1; run(5);

    // R10: busy shift register wakes the sleeping transmitter
    req = "R10"; tsr_empty = 0; run(2); tsr_empty = 1; run(4);

    // R5: write while asleep, idle still present
    req = "R5"; thr_wr = 1; run(1); thr_wr = 0;
    // R7: re-entry needs a further idle cycle
    req = "R7"; run(4);

    // R3: receive entry needs both conditions
    req = "R3"; auto_en_rx = 1; rx_fifo_empty = 1; run(4);
    rx_hunt = 1; rx_fifo_empty = 0; run(3);
    rx_fifo_empty = 1; run(5);

    // R6: falling then rising edge on the serial line
    req = "R6"; rxd_in = 0; run(6);
    rxd_in = 1; run(6);

    // R10: receive FIFO fills while asleep
    req = "R10"; rx_fifo_empty = 0; run(2); rx_fifo_empty = 1; run(4);

    // R4: auto disable while asleep
    req = "R4"; auto_en_tx = 0; auto_en_rx = 0; run(4);
    auto_en_tx = 1; auto_en_rx = 1; run(4);

    // R8: direct powerdown beats wake events
    req = "R8"; auto_en_tx = 0; auto_en_rx = 0; force_pd = 1; run(2);
    thr_wr = 1; rxd_in = 0; run(1); thr_wr = 0; run(4);
    force_pd = 0; run(3);
    auto_en_tx = 1; auto_en_rx = 1; force_pd = 1; run(2); force_pd = 0; run(3);

    // R9: ring indicator while asleep, clear, set beats clear
    req = "R9"; ri_in = 0; run(4);
    ri_clr = 1; run(1); ri_clr = 0; run(2);
    ri_in = 1; run(2); ri_clr = 1; run(1); ri_clr = 0; run(3);
    ri_clr = 1; run(2); ri_clr = 0; run(1);

    // mixed random stimulus, all requirements
    req = "R2/R3/R5/R6/R8/R9 random";
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 3000; k++) begin
      thr_wr        = ($urandom_range(0, 7) == 0);
      thr_empty     = ($urandom_range(0, 3) != 0);
      tsr_empty     = ($urandom_range(0, 3) != 0);
      rx_fifo_empty = ($urandom_range(0, 3) != 0);
      rx_hunt       = ($urandom_range(0, 3) != 0);
      rxd_in        = ($urandom_range(0, 9) == 0) ? ~rxd_in : rxd_in;
      ri_in         = ($urandom_range(0, 15) == 0) ? ~ri_in : ri_in;
      ri_clr        = ($urandom_range(0, 7) == 0);
      force_pd      = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) auto_en_tx = ~auto_en_tx;
      if ($urandom_range(0, 49) == 0) auto_en_rx = ~auto_en_rx;
      if ($urandom_range(0, 999) == 0) rst = 1'b1; else rst = 1'b0;
      tick();
    end
    rst = 0; run(2);
    summary();
  end

endmodule